// File: doc/BRIEF.md
# Multi-Format Frame Pulse Generator

This block derives a 125 µs telecom frame from one 16.384 MHz master clock. It also drives four frame markers and three divided bit clocks. A shared 11-bit frame counter runs through 2048 master cycles per frame. Every output is decoded from the value that counter is about to take and is then registered. As a result, all markers and clocks switch on the same master edge and never glitch.

There are four markers, and each has its own width, polarity and position:
- a short active-high start marker of 2 cycles;
- an active-low start marker of 4 cycles;
- a wide active-high start marker of 8 cycles;
- an active-high marker of 8 cycles that flags the close of the frame rather than its opening.

The 8.192, 4.096 and 2.048 MHz clocks come from the low counter bits. Each of these clocks is high during count 0, so its rising edge lines up with the frame boundary.

A frame-align strobe restarts the frame: the counter takes the value 0 at the next master edge. The block has no data stream, so there is no valid/ready interface. All pins are plain control and status.

Top module: `frame_pulse_gen`

## Requirements
- R1: The frame counter advances by one on each master edge and wraps from 2047 to 0. Every output pattern therefore repeats every 2048 master cycles.
- R2: `fp_end` is 1 exactly while the frame count is 2040 through 2047 (the last 8 cycles), and is 0 otherwise.
- R3: `fp_start_n` is 0 exactly while the frame count is 0 through 3, and is 1 otherwise.
- R4: `fp_start_long` is 1 exactly while the frame count is 0 through 7.
- R5: `fp_start_short` is 1 exactly while the frame count is 0 or 1.
- R6: `clk_8m`, `clk_4m` and `clk_2m` equal the inverse of frame-count bits 0, 1 and 2 respectively. All three are high at count 0.
- R7: When `align` is 1 at a master edge, the frame count after that edge is 0. While `align` stays 1, the count stays at 0.
- R8: While `rst` is 1 at a master edge, the following hold after that edge: the count is 0, `fp_start_n` is 1, the other markers are 0, and all divided clocks are 1. After release, the first edge gives count 1.
- R9: `fp_end` and `fp_start_short` are never 1 together. `fp_end` falls on the same edge at which the start markers become active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| align | input | 1 | Frame restart strobe, active high |
| fp_end | output | 1 | End-of-frame marker, 8 cycles, active high |
| fp_start_n | output | 1 | Start marker, 4 cycles, active low |
| fp_start_long | output | 1 | Start marker, 8 cycles, active high |
| fp_start_short | output | 1 | Start marker, 2 cycles, active high |
| clk_8m | output | 1 | Master clock divided by 2 |
| clk_4m | output | 1 | Master clock divided by 4 |
| clk_2m | output | 1 | Master clock divided by 8 |

## Verification
The hardest case to reach from the ports is the frame wrap. At the wrap, the end marker must hand over to the three start markers on a single edge, and this only happens 2048 cycles after the previous boundary. The stimulus therefore runs two full frames from reset, checking both sides of each wrap. It then forces a restart in mid-frame and counts a further 2047 edges, to confirm that the end marker lands exactly where the restarted frame says it should.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  parameter int FRAME_W = 11;
  parameter int DIV_N = 3;
  parameter int END_W = 8;
  parameter int LOWSTART_W = 4;
  parameter int LONGSTART_W = 8;
  parameter int SHORTSTART_W = 2;
endpackage

// File: rtl/fpg_counter.sv
module fpg_counter #(
  parameter int CNT_W = fpg_pkg::FRAME_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             align,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (rst || align) cnt_nxt = '0;
    else              cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) cnt_q <= cnt_nxt;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !align |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R7
  align_zero_chk: assert property (@(posedge clk) disable iff (rst)
    align |=> cnt_q == '0);
endmodule

// File: rtl/fpg_pulse.sv
module fpg_pulse #(
  parameter int CNT_W = fpg_pkg::FRAME_W,
  parameter int START = 0,
  parameter int WIDTH = 1,
  parameter bit ACT_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             pulse
);
  localparam logic [CNT_W-1:0] START_V = CNT_W'(START);
  localparam logic [CNT_W-1:0] WIDTH_V = CNT_W'(WIDTH);
  localparam logic IDLE = ACT_LOW;

  logic [CNT_W-1:0] offset;
  logic hit;

  always_comb begin
    offset = cnt_nxt - START_V;
    hit = offset < WIDTH_V;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse <= IDLE;
    else     pulse <= hit ^ ACT_LOW;
  end
endmodule

// File: rtl/fpg_divider.sv
module fpg_divider #(
  parameter int CNT_W = fpg_pkg::FRAME_W,
  parameter int DIV_N = fpg_pkg::DIV_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic [DIV_N-1:0] clk_div
);
  for (genvar k = 0; k < DIV_N; k++) begin : g_div
    always_ff @(posedge clk) begin
      if (rst) clk_div[k] <= 1'b1;
      else     clk_div[k] <= ~cnt_nxt[k];
    end
  end

  for (genvar k = 0; k + 1 < DIV_N; k++) begin : g_chk
    // R6
    slow_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(clk_div[k+1]) |-> clk_div[k]);
  end
endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen #(
  parameter int CNT_W = fpg_pkg::FRAME_W
) (
  input  logic clk,
  input  logic rst,
  input  logic align,
  output logic fp_end,
  output logic fp_start_n,
  output logic fp_start_long,
  output logic fp_start_short,
  output logic clk_8m,
  output logic clk_4m,
  output logic clk_2m
);
  localparam int FRAME_LEN = 1 << CNT_W;
  localparam int DIV_N = fpg_pkg::DIV_N;

  logic [CNT_W-1:0] cnt_nxt;
  logic [DIV_N-1:0] clk_div;

  fpg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .align(align), .cnt_nxt(cnt_nxt)
  );

  fpg_pulse #(.CNT_W(CNT_W), .START(FRAME_LEN - fpg_pkg::END_W),
              .WIDTH(fpg_pkg::END_W), .ACT_LOW(1'b0)) u_end (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .pulse(fp_end)
  );

  fpg_pulse #(.CNT_W(CNT_W), .START(0),
              .WIDTH(fpg_pkg::LOWSTART_W), .ACT_LOW(1'b1)) u_low (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .pulse(fp_start_n)
  );

  fpg_pulse #(.CNT_W(CNT_W), .START(0),
              .WIDTH(fpg_pkg::LONGSTART_W), .ACT_LOW(1'b0)) u_long (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .pulse(fp_start_long)
  );

  fpg_pulse #(.CNT_W(CNT_W), .START(0),
              .WIDTH(fpg_pkg::SHORTSTART_W), .ACT_LOW(1'b0)) u_short (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .pulse(fp_start_short)
  );

  fpg_divider #(.CNT_W(CNT_W), .DIV_N(DIV_N)) u_div (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .clk_div(clk_div)
  );

  assign clk_8m = clk_div[0];
  assign clk_4m = clk_div[1];
  assign clk_2m = clk_div[2];

  // R9
  end_start_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fp_end && fp_start_short));
  // R9
  end_handover_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fp_end) |-> fp_start_short && fp_start_long && !fp_start_n);
  // R5
  short_in_long_chk: assert property (@(posedge clk) disable iff (rst)
    fp_start_short |-> fp_start_long);
  // R3
  low_in_long_chk: assert property (@(posedge clk) disable iff (rst)
    !fp_start_n |-> fp_start_long);
  // R8
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> fp_start_n && !fp_end && !fp_start_long && !fp_start_short
            && clk_8m && clk_4m && clk_2m);
endmodule

// File: tb/frame_pulse_gen_tb.sv
module frame_pulse_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic align = 1'b0;
  logic fp_end, fp_start_n, fp_start_long, fp_start_short;
  logic clk_8m, clk_4m, clk_2m;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame_pulse_gen u_dut (
    .clk(clk), .rst(rst), .align(align),
    .fp_end(fp_end), .fp_start_n(fp_start_n),
    .fp_start_long(fp_start_long), .fp_start_short(fp_start_short),
    .clk_8m(clk_8m), .clk_4m(clk_4m), .clk_2m(clk_2m)
  );

  // order: {fp_end, fp_start_n, fp_start_long, fp_start_short, clk_8m, clk_4m, clk_2m}
  localparam int NV = 12;
  localparam int VN [NV] = '{1, 2, 3, 4, 7, 8, 2039, 2040, 2047, 2048, 4095, 4096};
  localparam logic [6:0] VE [NV] = '{
    7'b0011011, 7'b0010101, 7'b0010001, 7'b0110110, 7'b0110000, 7'b0100111,
    7'b0100000, 7'b1100111, 7'b1100000, 7'b0011111, 7'b1100000, 7'b0011111};

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input logic [6:0] exp);
    logic [6:0] got;
    got = {fp_end, fp_start_n, fp_start_long, fp_start_short, clk_8m, clk_4m, clk_2m};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cur;
    tick();
    tick();
    chk("R8 reset state", 7'b0100111);
    rst = 1'b0;
    cur = 0;
    // R1 R2 R3 R4 R5 R6 R9: frame walk across two wraps
    for (int i = 0; i < NV; i++) begin
      repeat (VN[i] - cur) tick();
      cur = VN[i];
      chk("R1 R2 R3 R4 R5 R6 R9 table", VE[i]);
    end
    repeat (100) tick();
    align = 1'b1;
    tick();
    align = 1'b0;
    chk("R7 align restart", 7'b0011111);
    tick();
    chk("R7 count one after align", 7'b0011011);
    repeat (2046) tick();
    chk("R7 R2 end marker after align", 7'b1100000);
    tick();
    chk("R1 R9 wrap after align", 7'b0011111);
    repeat (5) tick();
    align = 1'b1;
    repeat (3) tick();
    chk("R7 align held", 7'b0011111);
    align = 1'b0;
    repeat (2) tick();
    chk("R6 count two", 7'b0010101);
    rst = 1'b1;
    tick();
    chk("R8 mid-run reset", 7'b0100111);
    tick();
    chk("R8 reset held", 7'b0100111);
    rst = 1'b0;
    tick();
    chk("R8 first count after release", 7'b0011011);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule